// File: doc/BRIEF.md
# Descriptor-Chained Memory DMA Engine

This block copies blocks of bytes between memory locations on behalf of a host. The work is described by chains of 16-byte descriptors that the host writes into a small on-chip word RAM. The RAM is reached through a 16-bit host port, which also holds the channel registers. There are two channels. The host writes a start register, and each started channel finds its first descriptor through a 16-bit pointer stored in its own parameter slot inside the RAM.

The engine then walks the chain. For each descriptor it checks the valid flag, reads the length and the two pointers, and moves the bytes one at a time over a simple request/acknowledge memory port. It then writes the control word back with the valid flag cleared and updates the channel status. Each channel has a write-one-to-clear status register and a plain mask register. Its interrupt line is high whenever a status bit is set that the mask also enables.

The channels share one fetch/copy engine. A channel that is started while the other is running waits its turn, and its busy flag already reads as set while it waits.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, both status registers, both mask registers and the busy register read 0, both interrupt lines are low and no memory request is made.
- R2: Writing the start register (host address 0x0964) with bit 0 set starts channel 0, and with bit 1 set starts channel 1. Bit c of the busy register (0x0968) reads 1 from the next cycle until the channel finishes. A start written to a channel that is already busy is ignored.
- R3: A started channel reads its table base from the RAM word at RAM offset 0x1CC0 (channel 0) or 0x1DC0 (channel 1); RAM offset 0 is host address 0x2000. If a descriptor address lies below 0x2000 or above 0x3FF0, the channel stops with its status unchanged.
- R4: A descriptor is big-endian and 16 bytes long. Its control word is at +0, a function-code word that the engine ignores is at +2, the 32-bit length is at +4, the source pointer is at +8 and the destination pointer is at +12.
- R5: For a length of N, the engine reads bytes src..src+N-1 and writes each one to the matching address from dst upward. Each request is held with a stable address until it is acknowledged. A length of 0 makes no memory access.
- R6: After its transfer, the control word of a descriptor is written back to RAM with bit 15 cleared and every other bit kept.
- R7: A descriptor whose control bit 15 (valid) is 0 sets status bit 0 (out of buffers) and stops the channel without any transfer.
- R8: A processed descriptor with control bit 12 set sets status bit 2 (auxiliary done). One with control bit 11 set sets status bit 1 (chain done) and ends the chain.
- R9: After a descriptor that is not last, the next descriptor is at the current address plus 16. If control bit 13 (wrap) is set, the next descriptor is at the table base instead.
- R10: Writing a channel's status register (0x0910 for channel 0, 0x0918 for channel 1) clears the bits written as 1. The mask registers (0x0914, 0x091C) read back what was written. Interrupt line c is high exactly when status c AND mask c is nonzero.
- R11: A status bit that ends a chain becomes visible in the same cycle that the channel's busy bit drops.
- R12: When both channels are busy, channel 0 is served first, and channel 1 runs after channel 0 finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable (with host_sel) |
| host_addr | input | 14 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is acknowledged, and no request is made while no channel is busy;
- a channel's interrupt stays low while its mask is zero;
- the chain-done and out-of-buffers status bits rise only in the cycle that the channel's busy bit falls.

Only the directed scenarios can show the rest:
- the actual byte copies;
- the descriptor layout and the write-back values;
- wrap versus linear stepping;
- aborting on an out-of-window base;
- that a repeated start is ignored;
- that channel 0 goes first when both channels are started together.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int HAW       = 14,
  parameter int RAM_BYTES = 'h2000,
  parameter int RAM_BASE  = 'h2000,
  parameter int PARAM0    = 'h1CC0,
  parameter int PARAM1    = 'h1DC0,
  parameter int REG_ST0   = 'h0910,
  parameter int REG_MK0   = 'h0914,
  parameter int REG_ST1   = 'h0918,
  parameter int REG_MK1   = 'h091C,
  parameter int REG_GO    = 'h0964,
  parameter int REG_BUSY  = 'h0968
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_sel,
  input  logic            host_we,
  input  logic [HAW-1:0]  host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ack,
  output logic [1:0]      irq
);

  localparam int WORDS = RAM_BYTES / 2;
  localparam int AW    = $clog2(WORDS);
  localparam logic [AW-1:0] P0W = AW'(PARAM0 / 2);
  localparam logic [AW-1:0] P1W = AW'(PARAM1 / 2);
  localparam logic [HAW:0]  WIN_LO = (HAW+1)'(RAM_BASE);
  localparam logic [HAW:0]  WIN_HI = (HAW+1)'(RAM_BASE + RAM_BYTES);
  localparam logic [16:0]   BD_LO  = 17'(RAM_BASE);
  localparam logic [16:0]   BD_HI  = 17'(RAM_BASE + RAM_BYTES - 16);

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CHK, S_FETCH, S_RD, S_WR, S_WB} state_t;

  logic [15:0]      ram [WORDS];
  state_t           st;
  logic             ch;
  logic [2:0]       fi;
  logic [15:0]      tbl, bd, ctl;
  logic [31:0]      len, src, dst;
  logic [7:0]       byte_q;
  logic [1:0]       busy;
  logic [1:0][7:0]  sts, msk;

  logic             hw, in_ram, go, in_rng;
  logic [AW-1:0]    hidx, bdw, eidx;
  logic [15:0]      eword;
  logic             fin_ob, fin_wb, abort, done_now;
  logic [7:0]       setv;
  logic [1:0]       start;

  assign hw     = host_sel & host_we;
  assign in_ram = ({1'b0, host_addr} >= WIN_LO) && ({1'b0, host_addr} < WIN_HI);
  assign hidx   = AW'((host_addr - HAW'(RAM_BASE)) >> 1);
  assign go     = hw && (host_addr == HAW'(REG_GO));
  assign start  = {2{go}} & host_wdata[1:0] & ~busy;

  assign bdw    = AW'((bd - 16'(RAM_BASE)) >> 1);
  assign in_rng = ({1'b0, bd} >= BD_LO) && ({1'b0, bd} <= BD_HI);

  always_comb begin
    case (st)
      S_BASE:  eidx = ch ? P1W : P0W;
      S_WB:    eidx = bdw;
      default: eidx = bdw + AW'(fi);
    endcase
  end
  assign eword = ram[eidx];

  assign fin_ob   = (st == S_FETCH) && (fi == 3'd0) && !eword[15];
  assign fin_wb   = (st == S_WB);
  assign abort    = (st == S_CHK) && !in_rng;
  assign done_now = fin_ob | abort | (fin_wb & ctl[11]);
  assign setv     = fin_ob ? 8'h01 :
                    fin_wb ? {5'b0, ctl[12], ctl[11], 1'b0} : 8'h00;

  always_ff @(posedge clk) begin
    if (hw && in_ram) ram[hidx] <= host_wdata;
    if (fin_wb)       ram[eidx] <= ctl & 16'h7FFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= '0;
      msk  <= '0;
      busy <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [7:0] sc;
        sc = (ch == c[0]) ? setv : 8'h00;
        if (hw && host_addr == HAW'(c == 0 ? REG_ST0 : REG_ST1))
          sts[c] <= (sts[c] & ~host_wdata[7:0]) | sc;
        else
          sts[c] <= sts[c] | sc;
        if (hw && host_addr == HAW'(c == 0 ? REG_MK0 : REG_MK1))
          msk[c] <= host_wdata[7:0];
        busy[c] <= (busy[c] & ~(done_now && ch == c[0])) | start[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch     <= 1'b0;
      fi     <= '0;
      tbl    <= '0;
      bd     <= '0;
      ctl    <= '0;
      len    <= '0;
      src    <= '0;
      dst    <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (busy[0]) begin
            ch <= 1'b0;
            st <= S_BASE;
          end else if (busy[1]) begin
            ch <= 1'b1;
            st <= S_BASE;
          end
        end
        S_BASE: begin
          tbl <= eword;
          bd  <= eword;
          st  <= S_CHK;
        end
        S_CHK: begin
          fi <= '0;
          st <= in_rng ? S_FETCH : S_IDLE;
        end
        S_FETCH: begin
          fi <= fi + 3'd1;
          case (fi)
            3'd0: begin
              ctl <= eword;
              if (!eword[15]) st <= S_IDLE;
              else            fi <= 3'd2;
            end
            3'd2: len[31:16] <= eword;
            3'd3: len[15:0]  <= eword;
            3'd4: src[31:16] <= eword;
            3'd5: src[15:0]  <= eword;
            3'd6: dst[31:16] <= eword;
            3'd7: begin
              dst[15:0] <= eword;
              st <= (len == 32'd0) ? S_WB : S_RD;
            end
            default: ;
          endcase
        end
        S_RD: begin
          if (mem_ack) begin
            byte_q <= mem_rdata;
            st     <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ack) begin
            src <= src + 32'd1;
            dst <= dst + 32'd1;
            len <= len - 32'd1;
            st  <= (len == 32'd1) ? S_WB : S_RD;
          end
        end
        S_WB: begin
          if (ctl[11]) begin
            st <= S_IDLE;
          end else begin
            bd <= ctl[13] ? tbl : bd + 16'd16;
            st <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = byte_q;

  assign irq[0] = |(sts[0] & msk[0]);
  assign irq[1] = |(sts[1] & msk[1]);

  always_comb begin
    host_rdata = 16'h0000;
    if (in_ram)                                  host_rdata = ram[hidx];
    else if (host_addr == HAW'(REG_ST0))         host_rdata = {8'h00, sts[0]};
    else if (host_addr == HAW'(REG_MK0))         host_rdata = {8'h00, msk[0]};
    else if (host_addr == HAW'(REG_ST1))         host_rdata = {8'h00, sts[1]};
    else if (host_addr == HAW'(REG_MK1))         host_rdata = {8'h00, msk[1]};
    else if (host_addr == HAW'(REG_BUSY))        host_rdata = {14'h0000, busy};
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy == 2'b00 |-> !mem_req); // R2

  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0][1]) |-> $fell(busy[0])); // R11

  AST_OB_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1][0]) |-> $fell(busy[1])); // R7

  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    msk[0] == 8'h00 |-> !irq[0]); // R10

endmodule

// File: tb/test_dma_chain_engine.sv
`timescale 1ns/1ps
module test_dma_chain_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [13:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  localparam logic [13:0] A_ST0 = 14'h0910, A_MK0 = 14'h0914;
  localparam logic [13:0] A_ST1 = 14'h0918, A_MK1 = 14'h091C;
  localparam logic [13:0] A_GO = 14'h0964, A_BUSY = 14'h0968;
  localparam logic [13:0] A_P0 = 14'h3CC0, A_P1 = 14'h3DC0;

  always #10 clk = ~clk;

  dma_chain_engine i_dma_chain_engine (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq(irq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  logic [7:0]  mem [256];
  logic [31:0] alog [256];
  int          acc;
  logic        ack_q;

  assign mem_ack   = ack_q;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      ack_q <= 1'b0;
      acc   <= 0;
    end else begin
      ack_q <= mem_req && !ack_q;
      if (mem_req && ack_q) begin
        alog[acc[7:0]] <= mem_addr;
        acc <= acc + 1;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [13:0] a, logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(logic [13:0] a, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic put_desc(logic [13:0] a, logic [15:0] ctrl, logic [31:0] len,
                          logic [31:0] src, logic [31:0] dst);
    host_wr(a,       ctrl);
    host_wr(a + 2,   16'h5A5A);
    host_wr(a + 4,   len[31:16]);
    host_wr(a + 6,   len[15:0]);
    host_wr(a + 8,   src[31:16]);
    host_wr(a + 10,  src[15:0]);
    host_wr(a + 12,  dst[31:16]);
    host_wr(a + 14,  dst[15:0]);
  endtask

  task automatic wait_idle(logic [1:0] m, string req);
    logic [15:0] d;
    for (int i = 0; i < 3000; i++) begin
      host_rd(A_BUSY, d);
      if ((d[1:0] & m) == 2'b00) return;
    end
    check(req, 32'hDEAD, 32'h0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    host_rd(A_ST0, d);  check("R1 status0", d, 0);
    host_rd(A_ST1, d);  check("R1 status1", d, 0);
    host_rd(A_MK0, d);  check("R1 mask0", d, 0);
    host_rd(A_BUSY, d); check("R1 busy", d, 0);
    check("R1 irq", irq, 0);
    check("R1 no request", mem_req, 0);
  endtask

  task automatic t_single;
    logic [15:0] d;
    int a0;
    put_desc(14'h2100, 16'h9800, 4, 32'h1000_0010, 32'h2000_0080);
    host_wr(A_P0, 16'h2100);
    a0 = acc;
    host_wr(A_GO, 16'h0001);
    host_rd(A_BUSY, d); check("R2 busy after start", d[0], 1);
    wait_idle(2'b01, "R2 single timeout");
    for (int i = 0; i < 4; i++) check("R5 R4 copied byte", mem[8'h80 + i], pat(16 + i));
    check("R5 access count", acc - a0, 8);
    check("R5 first address", alog[a0[7:0]], 32'h1000_0010);
    host_rd(14'h2100, d); check("R6 ctrl written back", d, 16'h1800);
    host_rd(14'h2106, d); check("R4 length untouched", d, 16'h0004);
    host_rd(A_ST0, d);    check("R8 aux and chain done", d, 16'h0006);
    check("R10 irq low with zero mask", irq[0], 0);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    host_wr(A_MK0, 16'h0006);
    host_rd(A_MK0, d); check("R10 mask readback", d, 16'h0006);
    check("R10 irq raised", irq[0], 1);
    host_wr(A_ST0, 16'h0002);
    host_rd(A_ST0, d); check("R10 write-1-clear", d, 16'h0004);
    check("R10 irq still raised", irq[0], 1);
    host_wr(A_ST0, 16'h0004);
    host_rd(A_ST0, d); check("R10 all cleared", d, 16'h0000);
    check("R10 irq dropped", irq[0], 0);
    host_wr(A_MK0, 16'h0000);
  endtask

  task automatic t_chain;
    logic [15:0] d;
    logic seen;
    put_desc(14'h2200, 16'h9000, 2, 32'h20, 32'h90);
    put_desc(14'h2210, 16'h8800, 3, 32'h30, 32'h98);
    host_wr(A_P1, 16'h2200);
    host_wr(A_MK1, 16'h0002);
    host_wr(A_GO, 16'h0002);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      host_rd(A_BUSY, d);
      if (d[1] == 1'b0) begin
        seen = 1'b1;
        check("R11 done visible as busy drops", irq[1], 1);
      end
    end
    check("R11 chain finished", seen, 1);
    check("R9 byte 0", mem[8'h90], pat(8'h20));
    check("R9 byte 1", mem[8'h91], pat(8'h21));
    for (int i = 0; i < 3; i++) check("R9 second descriptor", mem[8'h98 + i], pat(8'h30 + i));
    host_rd(14'h2200, d); check("R6 first ctrl", d, 16'h1000);
    host_rd(14'h2210, d); check("R6 second ctrl", d, 16'h0800);
    host_rd(A_ST1, d);    check("R8 chain status", d, 16'h0006);
    host_wr(A_ST1, 16'h00FF);
    host_wr(A_MK1, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    int a0;
    put_desc(14'h2800, 16'hA000, 1, 32'h60, 32'hD0);
    put_desc(14'h2810, 16'h8800, 1, 32'h61, 32'hD1);
    host_wr(A_P0, 16'h2800);
    a0 = acc;
    host_wr(A_GO, 16'h0001);
    wait_idle(2'b01, "R9 wrap timeout");
    check("R9 wrap copied", mem[8'hD0], pat(8'h60));
    check("R9 wrap skipped next slot", acc - a0, 2);
    host_rd(14'h2810, d); check("R9 next slot untouched", d, 16'h8800);
    host_rd(14'h2800, d); check("R6 wrap ctrl", d, 16'h2000);
    host_rd(A_ST0, d);    check("R7 out of buffers after wrap", d, 16'h0001);
    host_wr(A_ST0, 16'h00FF);
  endtask

  task automatic t_invalid;
    logic [15:0] d;
    int a0;
    put_desc(14'h2700, 16'h0800, 2, 32'h70, 32'hE0);
    host_wr(A_P1, 16'h2700);
    a0 = acc;
    host_wr(A_GO, 16'h0002);
    wait_idle(2'b10, "R7 timeout");
    check("R7 no access", acc - a0, 0);
    host_rd(A_ST1, d);    check("R7 out of buffers", d, 16'h0001);
    host_rd(14'h2700, d); check("R7 ctrl unchanged", d, 16'h0800);
    host_wr(A_ST1, 16'h00FF);
  endtask

  task automatic t_zero;
    logic [15:0] d;
    int a0;
    put_desc(14'h2600, 16'h8800, 0, 32'h70, 32'hE0);
    host_wr(A_P0, 16'h2600);
    a0 = acc;
    host_wr(A_GO, 16'h0001);
    wait_idle(2'b01, "R5 zero timeout");
    check("R5 zero length no access", acc - a0, 0);
    host_rd(14'h2600, d); check("R6 zero ctrl", d, 16'h0800);
    host_rd(A_ST0, d);    check("R8 zero done", d, 16'h0002);
    host_wr(A_ST0, 16'h00FF);
  endtask

  task automatic t_abort(logic [15:0] base);
    logic [15:0] d;
    int a0;
    host_wr(A_P0, base);
    a0 = acc;
    host_wr(A_GO, 16'h0001);
    wait_idle(2'b01, "R3 abort timeout");
    check("R3 abort no access", acc - a0, 0);
    host_rd(A_ST0, d); check("R3 abort status unchanged", d, 16'h0000);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d;
    put_desc(14'h2400, 16'h8800, 20, 32'h40, 32'hA0);
    host_wr(A_P0, 16'h2400);
    host_wr(A_GO, 16'h0001);
    repeat (10) @(negedge clk);
    host_wr(A_GO, 16'h0001);
    host_rd(A_BUSY, d); check("R2 busy readback", d[0], 1);
    wait_idle(2'b01, "R2 busy timeout");
    for (int i = 0; i < 20; i++) check("R5 long copy", mem[8'hA0 + i], pat(8'h40 + i));
    repeat (20) @(negedge clk);
    host_rd(A_ST0, d); check("R2 restart ignored", d, 16'h0002);
    host_wr(A_ST0, 16'h00FF);
  endtask

  task automatic t_both;
    logic [15:0] d;
    int a0;
    put_desc(14'h2500, 16'h8800, 1, 32'h50, 32'hC0);
    put_desc(14'h2510, 16'h8800, 1, 32'h51, 32'hC1);
    host_wr(A_P0, 16'h2500);
    host_wr(A_P1, 16'h2510);
    a0 = acc;
    host_wr(A_GO, 16'h0003);
    host_rd(A_BUSY, d); check("R12 both busy", d, 16'h0003);
    wait_idle(2'b11, "R12 timeout");
    check("R12 channel 0 first", alog[a0[7:0]], 32'h50);
    check("R12 channel 1 after", alog[8'(a0 + 2)], 32'h51);
    check("R12 ch0 data", mem[8'hC0], pat(8'h50));
    check("R12 ch1 data", mem[8'hC1], pat(8'h51));
    host_wr(A_ST0, 16'h00FF);
    host_wr(A_ST1, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_irq();
    t_chain();
    t_wrap();
    t_invalid();
    t_zero();
    t_abort(16'h1000);
    t_abort(16'h3FF8);
    t_busy_ignore();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule